// File: doc/BRIEF.md
# Vector Quadrant Operand-Mode Decoder

This block decodes one major opcode reserved for vector work in a 32-bit instruction word. It takes the instruction and a valid flag. It splits out the register and function fields. For the quadrant that carries fused multiply-add, it works out which arithmetic operation the word encodes.

The word has no dedicated function field for the multiply-add quadrant. The operation follows from two facts about the three source operands: whether each is a vector or a scalar, and whether a scalar source names register zero. The multiply-add form computes src1*src2+src3 element by element, with a vector destination. Dropping the addend leaves a multiply. Dropping the multiplier leaves an add. Dropping the multiplicand leaves a subtract. Dropping two of the operands leaves a negate or a copy.

Two operand-mode combinations leave the arithmetic space. One is handed on unchanged as a predicate operation. The other opens an all-scalar extended region. The other three quadrants are reported only as a generic three-operand class, together with their 7-bit function number. The block is purely combinational and sits beside the scalar decode stage.

Top module: `vectorQuadDecoder`

## Requirements
- R1: When instrValid is low, or when bits 6:0 differ from the OPCODE parameter (default 7'h57), every output is zero, and opKind is 0 (none).
- R2: For an active word, rd = bits 11:7, funct3 = bits 14:12, rs1 = bits 19:15, rs2 = bits 24:20, quadrant = bits 26:25 and rs3 = bits 31:27.
- R3: An active word with quadrant 0, 1 or 2 gives opKind 9 (three-operand class) and triFunc = {quadrant, rs3}. All three scalar flags are 0. triFunc is zero for every other kind.
- R4: In quadrant 3, rs1Scalar = funct3[0], rs2Scalar = funct3[1] and rs3Scalar = funct3[2], where a set bit means scalar.
- R5: In quadrant 3 with all three funct3 bits set, rs3 = 0 gives opKind 2 (multiply), and any other rs3 gives opKind 8 (extended) with extFunc = rs3. extFunc is zero in every other case.
- R6: In quadrant 3 with funct3 = 3'b110 (rs1 vector, rs2 and rs3 scalar), opKind is 7 (predicate) and predPayload = {rs3, rs2, rs1, rd}. predPayload is zero otherwise.
- R7: Among the remaining quadrant-3 modes, rs1 and rs2 both scalar and numbered zero give opKind 6 (copy).
- R8: Otherwise, rs1 and rs3 both scalar and numbered zero give opKind 5 (negate).
- R9: Otherwise, rs1 scalar and numbered zero gives opKind 4 (subtract rs3-rs2).
- R10: Otherwise, rs2 scalar and numbered zero gives opKind 3 (add rs1+rs3).
- R11: Otherwise, rs3 scalar and numbered zero gives opKind 2 (multiply).
- R12: Otherwise the word gives opKind 1 (fused multiply-add). A vector operand numbered zero never triggers a special case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| instrValid | input | 1 | Word is present |
| isVector | output | 1 | Word carries the vector opcode and is valid |
| opKind | output | 4 | Operation class code |
| quadrant | output | 2 | Quadrant field |
| funct3 | output | 3 | Operand-mode field |
| rd | output | 5 | Destination register number |
| rs1 | output | 5 | First source (multiplicand) |
| rs2 | output | 5 | Second source (multiplier) |
| rs3 | output | 5 | Third source (addend) or function code |
| rs1Scalar | output | 1 | rs1 names a scalar register |
| rs2Scalar | output | 1 | rs2 names a scalar register |
| rs3Scalar | output | 1 | rs3 names a scalar register |
| predPayload | output | 20 | Forwarded predicate-operation bits |
| extFunc | output | 5 | Extended-region function code |
| triFunc | output | 7 | Three-operand quadrant function number |

## Verification
The sweep covers every quadrant and every funct3 mode. For each of these it tries all eight patterns of which source fields are register zero, once with the other fields nonzero and once with different nonzero numbers. This sweep separates a vector register zero from a scalar register zero. It also checks the order of precedence when two operands are zero at once, and it separates the predicate and extended modes from the legal multiply-add modes. Words with the wrong opcode and with the valid flag low are mixed in, to show that nothing leaks out when the block is inactive.

// File: rtl/vqd_pkg.sv
package vqd_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int QUAD_W  = 2;
  localparam int NSRC    = 3;
  localparam int PAY_W   = 4 * REG_W;
  localparam int TRI_W   = QUAD_W + REG_W;

  typedef enum logic [3:0] {
    OPK_NONE = 4'd0,
    OPK_FMA  = 4'd1,
    OPK_MUL  = 4'd2,
    OPK_ADD  = 4'd3,
    OPK_SUB  = 4'd4,
    OPK_NEG  = 4'd5,
    OPK_COPY = 4'd6,
    OPK_PRED = 4'd7,
    OPK_EXT  = 4'd8,
    OPK_TRI  = 4'd9
  } opKind_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [REG_W-1:0]  rd;
    logic [F3_W-1:0]   f3;
    logic [REG_W-1:0]  rs1;
    logic [REG_W-1:0]  rs2;
    logic [QUAD_W-1:0] quad;
    logic [REG_W-1:0]  rs3;
    logic [NSRC-1:0]   srcZero;
  } vqdRaw_t;

  typedef struct packed {
    logic active;
    logic fmaQuad;
    logic predSel;
    logic extSel;
    logic triSel;
  } vqdStrobe_t;

endpackage

// File: rtl/vqdFieldPath.sv
module vqdFieldPath
  import vqd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  vqdStrobe_t         strobe,
  output vqdRaw_t            raw,
  output logic [REG_W-1:0]   rdOut,
  output logic [F3_W-1:0]    funct3Out,
  output logic [REG_W-1:0]   rs1Out,
  output logic [REG_W-1:0]   rs2Out,
  output logic [QUAD_W-1:0]  quadOut,
  output logic [REG_W-1:0]   rs3Out,
  output logic [PAY_W-1:0]   payOut,
  output logic [REG_W-1:0]   extOut,
  output logic [TRI_W-1:0]   triOut
);
  localparam int RD_LO   = OPC_W;
  localparam int F3_LO   = RD_LO + REG_W;
  localparam int RS1_LO  = F3_LO + F3_W;
  localparam int RS2_LO  = RS1_LO + REG_W;
  localparam int QUAD_LO = RS2_LO + REG_W;
  localparam int RS3_LO  = QUAD_LO + QUAD_W;

  logic [REG_W-1:0] srcField [NSRC];

  assign srcField[0] = instr[RS1_LO +: REG_W];
  assign srcField[1] = instr[RS2_LO +: REG_W];
  assign srcField[2] = instr[RS3_LO +: REG_W];

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : gZero
      assign raw.srcZero[gi] = (srcField[gi] == '0);
    end
  endgenerate

  assign raw.opcode = instr[0 +: OPC_W];
  assign raw.rd     = instr[RD_LO +: REG_W];
  assign raw.f3     = instr[F3_LO +: F3_W];
  assign raw.rs1    = srcField[0];
  assign raw.rs2    = srcField[1];
  assign raw.quad   = instr[QUAD_LO +: QUAD_W];
  assign raw.rs3    = srcField[2];

  always_comb begin
    rdOut     = strobe.active ? raw.rd   : '0;
    funct3Out = strobe.active ? raw.f3   : '0;
    rs1Out    = strobe.active ? raw.rs1  : '0;
    rs2Out    = strobe.active ? raw.rs2  : '0;
    quadOut   = strobe.active ? raw.quad : '0;
    rs3Out    = strobe.active ? raw.rs3  : '0;
    payOut    = strobe.predSel ? {raw.rs3, raw.rs2, raw.rs1, raw.rd} : '0;
    extOut    = strobe.extSel ? raw.rs3 : '0;
    triOut    = strobe.triSel ? {raw.quad, raw.rs3} : '0;
  end

endmodule

// File: rtl/vqdControl.sv
module vqdControl
  import vqd_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPCODE = 7'h57
) (
  input  logic           instrValid,
  input  vqdRaw_t        raw,
  output vqdStrobe_t     strobe,
  output opKind_e        kind,
  output logic [NSRC-1:0] srcScalar
);
  localparam logic [QUAD_W-1:0] FMA_QUAD = '1;

  logic            active;
  logic            fmaQuad;
  logic [NSRC-1:0] scalarSel;
  logic [NSRC-1:0] zeroScalar;
  logic            allScalar;
  logic            predMode;

  assign active    = instrValid && (raw.opcode == OPCODE);
  assign fmaQuad   = active && (raw.quad == FMA_QUAD);
  assign scalarSel = raw.f3;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : gSpecial
      assign zeroScalar[gi] = scalarSel[gi] && raw.srcZero[gi];
    end
  endgenerate

  assign allScalar = &scalarSel;
  assign predMode  = !scalarSel[0] && scalarSel[1] && scalarSel[2];

  always_comb begin
    kind = OPK_NONE;
    if (active && !fmaQuad) begin
      kind = OPK_TRI;
    end else if (fmaQuad) begin
      if (allScalar)                         kind = raw.srcZero[2] ? OPK_MUL : OPK_EXT;
      else if (predMode)                     kind = OPK_PRED;
      else if (zeroScalar[0] && zeroScalar[1]) kind = OPK_COPY;
      else if (zeroScalar[0] && zeroScalar[2]) kind = OPK_NEG;
      else if (zeroScalar[0])                kind = OPK_SUB;
      else if (zeroScalar[1])                kind = OPK_ADD;
      else if (zeroScalar[2])                kind = OPK_MUL;
      else                                   kind = OPK_FMA;
    end
  end

  always_comb begin
    strobe.active  = active;
    strobe.fmaQuad = fmaQuad;
    strobe.predSel = (kind == OPK_PRED);
    strobe.extSel  = (kind == OPK_EXT);
    strobe.triSel  = (kind == OPK_TRI);
  end

  assign srcScalar = fmaQuad ? scalarSel : '0;

endmodule

// File: rtl/vectorQuadDecoder.sv
module vectorQuadDecoder
  import vqd_pkg::*;
#(
  parameter logic [6:0] OPCODE = 7'h57
) (
  input  logic [31:0] instr,
  input  logic        instrValid,
  output logic        isVector,
  output logic [3:0]  opKind,
  output logic [1:0]  quadrant,
  output logic [2:0]  funct3,
  output logic [4:0]  rd,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2,
  output logic [4:0]  rs3,
  output logic        rs1Scalar,
  output logic        rs2Scalar,
  output logic        rs3Scalar,
  output logic [19:0] predPayload,
  output logic [4:0]  extFunc,
  output logic [6:0]  triFunc
);
  vqdRaw_t         raw;
  vqdStrobe_t      strobe;
  opKind_e         kind;
  logic [NSRC-1:0] srcScalar;

  vqdFieldPath fieldPath_i (
    .instr     (instr),
    .strobe    (strobe),
    .raw       (raw),
    .rdOut     (rd),
    .funct3Out (funct3),
    .rs1Out    (rs1),
    .rs2Out    (rs2),
    .quadOut   (quadrant),
    .rs3Out    (rs3),
    .payOut    (predPayload),
    .extOut    (extFunc),
    .triOut    (triFunc)
  );

  vqdControl #(.OPCODE(OPCODE)) control_i (
    .instrValid (instrValid),
    .raw        (raw),
    .strobe     (strobe),
    .kind       (kind),
    .srcScalar  (srcScalar)
  );

  assign isVector  = strobe.active;
  assign opKind    = kind;
  assign rs1Scalar = srcScalar[0];
  assign rs2Scalar = srcScalar[1];
  assign rs3Scalar = srcScalar[2];

endmodule

// File: rtl/vqdChecker.sv
module vqdChecker (
  input logic [31:0] instr,
  input logic        instrValid,
  input logic        isVector,
  input logic [3:0]  opKind,
  input logic [1:0]  quadrant,
  input logic [2:0]  funct3,
  input logic [4:0]  rd,
  input logic [4:0]  rs1,
  input logic [4:0]  rs2,
  input logic [4:0]  rs3,
  input logic        rs1Scalar,
  input logic        rs2Scalar,
  input logic        rs3Scalar,
  input logic [19:0] predPayload,
  input logic [4:0]  extFunc,
  input logic [6:0]  triFunc
);
  always_comb begin
    if (!instrValid) begin
      assert_invalid_quiet_R1: assert (!isVector && opKind == 4'd0 && predPayload == '0
                                        && rd == '0 && rs3 == '0 && triFunc == '0)
        else $error("invalid word produced output");
    end
    if (isVector) begin
      assert_fields_follow_R2: assert (rd == instr[11:7] && rs1 == instr[19:15]
                                        && quadrant == instr[26:25] && rs3 == instr[31:27])
        else $error("field mismatch");
    end
    if (triFunc != '0) begin
      assert_tri_class_R3: assert (opKind == 4'd9) else $error("triFunc outside tri class");
    end
    if (rs1Scalar || rs2Scalar || rs3Scalar) begin
      assert_flags_in_fma_quad_R4: assert (quadrant == 2'b11) else $error("scalar flag outside quadrant 3");
    end
    if (extFunc != '0) begin
      assert_ext_class_R5: assert (opKind == 4'd8 && rs1Scalar && rs2Scalar && rs3Scalar)
        else $error("extFunc outside extended region");
    end
    if (predPayload != '0) begin
      assert_pred_class_R6: assert (opKind == 4'd7 && !rs1Scalar) else $error("payload outside predicate");
    end
    if (opKind == 4'd1) begin
      assert_fma_no_scalar_zero_R12: assert (!(rs1Scalar && rs1 == '0) && !(rs2Scalar && rs2 == '0)
                                             && !(rs3Scalar && rs3 == '0))
        else $error("fma with scalar zero");
    end
  end
endmodule

bind vectorQuadDecoder vqdChecker vqdChecker_i (
  .instr       (instr),
  .instrValid  (instrValid),
  .isVector    (isVector),
  .opKind      (opKind),
  .quadrant    (quadrant),
  .funct3      (funct3),
  .rd          (rd),
  .rs1         (rs1),
  .rs2         (rs2),
  .rs3         (rs3),
  .rs1Scalar   (rs1Scalar),
  .rs2Scalar   (rs2Scalar),
  .rs3Scalar   (rs3Scalar),
  .predPayload (predPayload),
  .extFunc     (extFunc),
  .triFunc     (triFunc)
);

// File: tb/vectorQuadDecoder_tb_top.sv
`timescale 1ns/1ps
module vectorQuadDecoder_tb_top;
  localparam logic [6:0] OPC = 7'h57;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr;
  logic        instrValid;
  logic        isVector;
  logic [3:0]  opKind;
  logic [1:0]  quadrant;
  logic [2:0]  funct3;
  logic [4:0]  rd, rs1, rs2, rs3;
  logic        rs1Scalar, rs2Scalar, rs3Scalar;
  logic [19:0] predPayload;
  logic [4:0]  extFunc;
  logic [6:0]  triFunc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  vectorQuadDecoder #(.OPCODE(OPC)) dut_i (
    .instr(instr), .instrValid(instrValid), .isVector(isVector), .opKind(opKind),
    .quadrant(quadrant), .funct3(funct3), .rd(rd), .rs1(rs1), .rs2(rs2), .rs3(rs3),
    .rs1Scalar(rs1Scalar), .rs2Scalar(rs2Scalar), .rs3Scalar(rs3Scalar),
    .predPayload(predPayload), .extFunc(extFunc), .triFunc(triFunc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (instr=%08h valid=%0b)", tag, act, exp, instr, instrValid);
    end
  endtask

  function automatic string kindTag(input logic [3:0] k);
    case (k)
      4'd1: return "R12";
      4'd2: return "R11";
      4'd3: return "R10";
      4'd4: return "R9";
      4'd5: return "R8";
      4'd6: return "R7";
      4'd7: return "R6";
      4'd8: return "R5";
      4'd9: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input logic v);
    @(negedge clk);
    instr = w;
    instrValid = v;
    @(posedge clk);
    #1;
  endtask

  // expected quadrant-3 kind from operand modes and zero fields
  function automatic logic [3:0] expFmaKind(input logic [2:0] f3, input logic [4:0] a,
                                            input logic [4:0] b, input logic [4:0] c);
    logic z1, z2, z3;
    z1 = f3[0] && (a == 0);
    z2 = f3[1] && (b == 0);
    z3 = f3[2] && (c == 0);
    if (f3 == 3'b111)      return (c == 0) ? 4'd2 : 4'd8;
    if (f3 == 3'b110)      return 4'd7;
    if (z1 && z2)          return 4'd6;
    if (z1 && z3)          return 4'd5;
    if (z1)                return 4'd4;
    if (z2)                return 4'd3;
    if (z3)                return 4'd2;
    return 4'd1;
  endfunction

  task automatic checkInactive(input string why);
    check({"R1 kind ", why}, 64'(opKind), 64'd0);
    check({"R1 fields ", why},
          64'({isVector, quadrant, funct3, rd, rs1, rs2, rs3, rs1Scalar, rs2Scalar, rs3Scalar}), 64'd0);
    check({"R1 side ", why}, 64'({predPayload, extFunc, triFunc}), 64'd0);
  endtask

  initial begin
    instr = '0;
    instrValid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    checkInactive("reset idle");

    for (int set = 0; set < 2; set++) begin
      for (int q = 0; q < 4; q++) begin
        for (int f = 0; f < 8; f++) begin
          for (int zm = 0; zm < 8; zm++) begin
            logic [4:0] a, b, c, d;
            logic [31:0] w;
            logic [3:0] ek;
            a = zm[0] ? 5'd0 : 5'(3 + set * 17);
            b = zm[1] ? 5'd0 : 5'(9 + set * 13);
            c = zm[2] ? 5'd0 : 5'(21 + set * 9);
            d = 5'(q * 7 + f + set);
            w = {c, 2'(q), b, a, 3'(f), d, OPC};
            apply(w, 1'b1);
            ek = (q == 3) ? expFmaKind(3'(f), a, b, c) : 4'd9;
            check(kindTag(ek), 64'(opKind), 64'(ek));
            check("R2 fields", 64'({isVector, quadrant, funct3, rd, rs1, rs2, rs3}),
                  64'({1'b1, 2'(q), 3'(f), d, a, b, c}));
            check((q == 3) ? "R4 flags" : "R3 flags", 64'({rs3Scalar, rs2Scalar, rs1Scalar}),
                  (q == 3) ? 64'(f) : 64'd0);
            check("R3 triFunc", 64'(triFunc), (ek == 4'd9) ? 64'({2'(q), c}) : 64'd0);
            check("R5 extFunc", 64'(extFunc), (ek == 4'd8) ? 64'(c) : 64'd0);
            check("R6 payload", 64'(predPayload), (ek == 4'd7) ? 64'({c, b, a, d}) : 64'd0);
            // same word, valid low, then wrong opcode
            apply(w, 1'b0);
            checkInactive("valid low");
            apply({w[31:7], OPC ^ 7'(1 << (zm % 7))}, 1'b1);
            checkInactive("opcode mismatch");
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule